// File: doc/BRIEF.md
# CAN Transmit Dominant-Timeout Guard

This block is the digital control for the transmit side of a CAN physical-layer interface. It takes the transmit bit stream from the protocol controller, a silent-mode select and already-synchronized thermal and supply fault flags. From these it drives two signals to the analog bus driver: an enable, and a request to drive the bus dominant. When the driver is not enabled, the bus is left recessive.

A watchdog protects the bus from a stuck-dominant transmitter. It arms on each falling edge of the synchronized TXD and counts clock cycles while TXD stays low. If the low time reaches the timeout, the watchdog disables the driver and raises a status flag. The condition clears only when TXD is seen recessive again. The timeout sets the lowest usable bit rate: eleven successive dominant bits must fit inside it, so the minimum rate is 11 divided by the timeout.

The driver is also off in silent mode, during thermal shutdown and during supply undervoltage. After both undervoltage flags clear, and after reset, the driver stays off for a recovery delay. At the default parameters this is 12000 cycles, which is 300 µs at a 40 MHz clock.

TXD is a plain level input that is sampled on every clock. It has no valid/ready handshake, because a bus bit stream cannot be held back. No input or output applies back-pressure.

Top module: `can_tx_guard`

## Requirements
- R1: While `silent_i` is high, `drv_en_o` and `drv_dom_o` are both low, whatever TXD does.
- R2: In normal mode with no fault, no timeout and the recovery delay complete, `drv_en_o` is high and `drv_dom_o` is the inverse of TXD delayed by the two-flop synchronizer. A TXD change made before clock edge e appears at `drv_dom_o` just after edge e+1.
- R3: `tmo_o` rises after the edge at which the synchronized TXD has been sampled low on TMO_CYCLES consecutive edges, counted from its falling edge.
- R4: A rising edge of the synchronized TXD before that count is reached cancels the timer. The next falling edge restarts the full count, so a low run of TMO_CYCLES-1 samples never sets `tmo_o`.
- R5: While `tmo_o` is high, `drv_en_o` and `drv_dom_o` are low.
- R6: `tmo_o` falls on the first edge at which the synchronized TXD is sampled high (recessive). Changes of mode, thermal flag or supply flags do not clear it.
- R7: While `therm_flt_i` is high, the driver is off in the same cycle. The driver is usable again in the cycle the flag falls.
- R8: While `uv_main_i` or `uv_io_i` is high, the driver is off in the same cycle.
- R9: After reset, and after both undervoltage flags fall, the driver stays off until RESUME_CYCLES edges have been sampled with both flags low. Any undervoltage during this wait restarts it.
- R10: The timeout timer runs in every mode, so `tmo_o` can be set while in silent mode.
- R11: During and right after reset, `drv_en_o`, `drv_dom_o` and `tmo_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| txd_i | input | 1 | Transmit bit stream, low = dominant, asynchronous |
| silent_i | input | 1 | High selects silent (receive-only) mode |
| therm_flt_i | input | 1 | Thermal shutdown flag, synchronized |
| uv_main_i | input | 1 | Main supply undervoltage flag, synchronized |
| uv_io_i | input | 1 | I/O supply undervoltage flag, synchronized |
| drv_en_o | output | 1 | Bus driver enable |
| drv_dom_o | output | 1 | Drive-dominant request to the bus driver |
| tmo_o | output | 1 | TXD dominant-timeout status |

## Verification
A wrong timeout count shows at the ports within one cycle of the boundary. In that cycle `tmo_o` rises early or late and `drv_en_o` drops with it. The runs one sample below the limit and exactly at the limit are the sharpest probes. A recovery counter that does not restart on a repeated undervoltage pulse keeps the driver off for too short a time, and this shows at the edge where the restarted delay should end. A timeout that clears on the wrong event shows as `drv_en_o` returning while TXD is still dominant, or staying low after TXD returns recessive.

// File: rtl/can_txg_pkg.sv
package can_txg_pkg;

  // Reason the driver is (or is not) enabled, in priority order.
  typedef enum logic [2:0] {
    GATE_PROT   = 3'd0,
    GATE_THERM  = 3'd1,
    GATE_SILENT = 3'd2,
    GATE_TMO    = 3'd3,
    GATE_DRIVE  = 3'd4
  } gate_e;

  // Bus level encoding on the logic side.
  localparam logic LVL_RECESSIVE = 1'b1;
  localparam logic LVL_DOMINANT  = 1'b0;

endpackage

// File: rtl/can_txg_sync.sv
module can_txg_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= RST_VAL;
    else        chain_q[0] <= d_i;
  end

  // The remaining stages form a shift chain.
  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[g] <= RST_VAL;
      else        chain_q[g] <= chain_q[g-1];
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/can_txg_dto.sv
module can_txg_dto
  import can_txg_pkg::*;
#(
  parameter int TMO_CYCLES = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txd_s_i,
  output logic tripped_o
);

  localparam int CW = $clog2(TMO_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(TMO_CYCLES - 1);

  logic          prev_q;
  logic          running_q;
  logic          tripped_q;
  logic [CW-1:0] cnt_q;
  logic          fall;

  // The timer arms on a recessive-to-dominant transition of the synchronized input.
  assign fall = (prev_q == LVL_RECESSIVE) && (txd_s_i == LVL_DOMINANT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= LVL_RECESSIVE;
    else        prev_q <= txd_s_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      tripped_q <= 1'b0;
      cnt_q     <= '0;
    end else if (txd_s_i == LVL_RECESSIVE) begin
      // A recessive sample cancels the timer and clears a timeout.
      running_q <= 1'b0;
      tripped_q <= 1'b0;
      cnt_q     <= '0;
    end else if (fall) begin
      running_q <= 1'b1;
      cnt_q     <= CW'(1);
    end else if (running_q) begin
      if (cnt_q == LAST) begin
        tripped_q <= 1'b1;
        running_q <= 1'b0;
      end
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign tripped_o = tripped_q;

endmodule

// File: rtl/can_txg_resume.sv
module can_txg_resume #(
  parameter int RESUME_CYCLES = 12000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uv_any_i,
  output logic ok_o
);

  localparam int RW = $clog2(RESUME_CYCLES + 1);
  localparam logic [RW-1:0] LAST = RW'(RESUME_CYCLES - 1);

  logic [RW-1:0] cnt_q;
  logic          ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ok_q  <= 1'b0;
    end else if (uv_any_i) begin
      cnt_q <= '0;
      ok_q  <= 1'b0;
    end else if (!ok_q) begin
      if (cnt_q == LAST) ok_q <= 1'b1;
      else               cnt_q <= cnt_q + RW'(1);
    end
  end

  assign ok_o = ok_q;

endmodule

// File: rtl/can_txg_gate.sv
module can_txg_gate
  import can_txg_pkg::*;
(
  input  logic silent_i,
  input  logic therm_i,
  input  logic uv_any_i,
  input  logic supply_ok_i,
  input  logic tripped_i,
  input  logic txd_s_i,
  output logic drv_en_o,
  output logic drv_dom_o
);

  gate_e gate;

  always_comb begin
    if (uv_any_i || !supply_ok_i) gate = GATE_PROT;
    else if (therm_i)             gate = GATE_THERM;
    else if (silent_i)            gate = GATE_SILENT;
    else if (tripped_i)           gate = GATE_TMO;
    else                          gate = GATE_DRIVE;
  end

  always_comb begin
    drv_en_o  = (gate == GATE_DRIVE);
    drv_dom_o = drv_en_o && (txd_s_i == LVL_DOMINANT);
  end

endmodule

// File: rtl/can_tx_guard.sv
module can_tx_guard #(
  parameter int SYNC_STAGES   = 2,
  parameter int TMO_CYCLES    = 4000,
  parameter int RESUME_CYCLES = 12000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txd_i,
  input  logic silent_i,
  input  logic therm_flt_i,
  input  logic uv_main_i,
  input  logic uv_io_i,
  output logic drv_en_o,
  output logic drv_dom_o,
  output logic tmo_o
);

  logic txd_s;
  logic uv_any;
  logic supply_ok;
  logic tripped;

  assign uv_any = uv_main_i | uv_io_i;

  can_txg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (txd_i),
    .q_o   (txd_s)
  );

  can_txg_dto #(.TMO_CYCLES(TMO_CYCLES)) u_dto (
    .clk       (clk),
    .rst_n     (rst_n),
    .txd_s_i   (txd_s),
    .tripped_o (tripped)
  );

  can_txg_resume #(.RESUME_CYCLES(RESUME_CYCLES)) u_resume (
    .clk      (clk),
    .rst_n    (rst_n),
    .uv_any_i (uv_any),
    .ok_o     (supply_ok)
  );

  can_txg_gate u_gate (
    .silent_i    (silent_i),
    .therm_i     (therm_flt_i),
    .uv_any_i    (uv_any),
    .supply_ok_i (supply_ok),
    .tripped_i   (tripped),
    .txd_s_i     (txd_s),
    .drv_en_o    (drv_en_o),
    .drv_dom_o   (drv_dom_o)
  );

  assign tmo_o = tripped;

endmodule

// File: rtl/can_tx_guard_chk.sv
module can_tx_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic silent_i,
  input logic therm_flt_i,
  input logic uv_main_i,
  input logic uv_io_i,
  input logic txd_sync,
  input logic drv_en_o,
  input logic drv_dom_o,
  input logic tmo_o
);

  p_silent_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    silent_i |-> (!drv_en_o && !drv_dom_o));

  p_dom_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    drv_dom_o |-> drv_en_o);

  p_tmo_rise_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_o) |-> !$past(txd_sync));

  p_tmo_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_o |-> (!drv_en_o && !drv_dom_o));

  p_tmo_clear_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tmo_o) |-> $past(txd_sync));

  p_therm_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    therm_flt_i |-> !drv_en_o);

  p_uv_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_main_i || uv_io_i) |-> !drv_en_o);

  p_uv_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(uv_main_i || uv_io_i) && !(uv_main_i || uv_io_i)) |-> !drv_en_o);

endmodule

bind can_tx_guard can_tx_guard_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .silent_i    (silent_i),
  .therm_flt_i (therm_flt_i),
  .uv_main_i   (uv_main_i),
  .uv_io_i     (uv_io_i),
  .txd_sync    (txd_s),
  .drv_en_o    (drv_en_o),
  .drv_dom_o   (drv_dom_o),
  .tmo_o       (tmo_o)
);

// File: tb/test_can_tx_guard.sv
`timescale 1ns/1ps
module test_can_tx_guard;

  localparam int TMO = 20;
  localparam int RES = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txd = 1'b1, silent = 1'b0, therm = 1'b0, uvm = 1'b0, uvi = 1'b0;
  logic drv_en, drv_dom, tmo;

  always #4 clk = ~clk;

  can_tx_guard #(.SYNC_STAGES(2), .TMO_CYCLES(TMO), .RESUME_CYCLES(RES)) i_can_tx_guard (
    .clk(clk), .rst_n(rst_n), .txd_i(txd), .silent_i(silent),
    .therm_flt_i(therm), .uv_main_i(uvm), .uv_io_i(uvi),
    .drv_en_o(drv_en), .drv_dom_o(drv_dom), .tmo_o(tmo)
  );

  // Behavioural reference: sample history, low-run length, recovery wait.
  int   checks = 0, fails = 0, cyc = 0;
  bit   done = 0;
  logic hist[$];
  int   low_run = 0, wait_cnt = 0;
  bit   m_tmo = 0, m_ok = 0;
  string req = "R11";

  function automatic logic sync_txd();
    return hist[hist.size()-1];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{1'b1, 1'b1};
      low_run = 0; m_tmo = 0; wait_cnt = 0; m_ok = 0;
    end else begin
      if (sync_txd()) begin low_run = 0; m_tmo = 0; end
      else begin
        if (low_run < TMO) low_run++;
        if (low_run >= TMO) m_tmo = 1;
      end
      if (uvm || uvi) begin wait_cnt = 0; m_ok = 0; end
      else if (!m_ok) begin wait_cnt++; if (wait_cnt == RES) m_ok = 1; end
      void'(hist.pop_back());
      hist.push_front(txd);
    end
  end

  task automatic cmp(string r, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at cycle %0d", r, what, act, exp, cyc);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      logic e_en;
      @(negedge clk);
      e_en = !silent && !therm && !uvm && !uvi && m_ok && !m_tmo;
      cmp(req, "drv_en", drv_en, e_en);
      cmp(req, "drv_dom", drv_dom, e_en && !sync_txd());
      cmp(req, "tmo", tmo, m_tmo);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk);
    req = "R11";
    cmp("R11", "drv_en in reset", drv_en, 1'b0);
    cmp("R11", "tmo in reset", tmo, 1'b0);
    rst_n = 1'b1;
    // R9: startup recovery wait
    req = "R9";
    step(RES - 1);
    cmp("R9", "driver still off before wait ends", drv_en, 1'b0);
    step(3);
    cmp("R9", "driver on after wait", drv_en, 1'b1);

    // R2: normal toggling, several patterns
    req = "R2";
    for (int i = 0; i < 30; i++) begin
      txd = (i % 3 == 0); step(1);
    end
    for (int i = 0; i < 16; i++) begin
      txd = i[1]; step(1);
    end
    txd = 1'b1; step(4);

    // R4: low run one sample short of the limit never trips
    req = "R4";
    txd = 1'b0; step(TMO - 1);
    txd = 1'b1; step(4);
    cmp("R4", "no timeout at TMO-1", tmo, 1'b0);
    txd = 1'b0; step(TMO - 1);
    txd = 1'b1; step(1);
    txd = 1'b0; step(TMO - 1);
    txd = 1'b1; step(4);
    cmp("R4", "restarted count", tmo, 1'b0);

    // R3 / R5: exact limit trips, driver off
    req = "R3";
    txd = 1'b0; step(TMO + 1);
    req = "R5";
    step(2);
    cmp("R5", "timeout blocks driver", drv_en, 1'b0);
    cmp("R3", "timeout flag set", tmo, 1'b1);

    // R6: mode and fault changes do not clear; recessive does
    req = "R6";
    silent = 1'b1; step(3); silent = 1'b0;
    therm = 1'b1; step(3); therm = 1'b0;
    uvm = 1'b1; step(2); uvm = 1'b0; step(RES + 2);
    cmp("R6", "flag held while TXD low", tmo, 1'b1);
    txd = 1'b1; step(4);
    cmp("R6", "flag cleared by recessive", tmo, 1'b0);

    // R1: silent mode with TXD activity
    req = "R1";
    silent = 1'b1;
    for (int i = 0; i < 10; i++) begin txd = i[0]; step(1); end
    // R10: timer runs in silent mode
    req = "R10";
    txd = 1'b0; step(TMO + 3);
    cmp("R10", "timeout set in silent", tmo, 1'b1);
    txd = 1'b1; step(3); silent = 1'b0; step(2);

    // R7: thermal gating, immediate release
    req = "R7";
    txd = 1'b0; step(3);
    therm = 1'b1; step(4);
    therm = 1'b0; step(1);
    cmp("R7", "driver back after thermal", drv_en, 1'b1);
    txd = 1'b1; step(3);

    // R8 / R9: undervoltage on each supply, restart of wait
    req = "R8";
    uvi = 1'b1; step(3); uvi = 1'b0;
    req = "R9";
    step(RES / 2);
    uvm = 1'b1; step(1); uvm = 1'b0;
    step(RES - 1);
    cmp("R9", "restarted wait still off", drv_en, 1'b0);
    step(3);
    cmp("R9", "driver on after restarted wait", drv_en, 1'b1);
    req = "R8";
    uvm = 1'b1; uvi = 1'b1; step(4); uvm = 1'b0; uvi = 1'b0;
    step(RES + 3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule